// File: doc/BRIEF.md
# Prescaled Basic Timer

A general-purpose interval timer with a register port for reads and writes. A count register steps toward a terminal value at a rate set by a 16-bit prescaler. The count runs downward to zero or upward to the all-ones value of its width. When the count reaches that value, a sticky status flag is raised. A level interrupt follows that flag, gated by an enable register. The counter width is a parameter and may be 16 or 32 bits. In the 16-bit build, only the low half of the count and preload registers is stored, and the upper half reads as zero.

Software loads a preload value and then writes the control register. That write sets the prescale value, the direction and the restart mode. It also sets three levels, run enable, start and halt, and can issue two one-shot commands: copy preload into count, and return everything to defaults. In one-shot mode the timer clears its own start bit when the count reaches the terminal value. In auto-restart mode it reloads the count from preload and keeps running, which gives a periodic tick.

Top module: `prescaled_timer`

## Requirements
- R1: Registers are decoded at byte offsets 0x00 (count), 0x04 (preload), 0x08 (status, bit 0), 0x0C (interrupt enable, bit 0) and 0x10 (control). All of them read zero after reset.
- R2: With a 16-bit counter, a write stores only bits 15:0 of count and preload, and bits 31:16 of those registers read as zero.
- R3: The control layout is bit 0 run enable, bit 2 count up (0 = down), bit 3 auto-restart, bit 5 start, bit 7 halt, and bits 31:16 prescale P. While enable=1, start=1 and halt=0, the count changes once every P+1 clock cycles. The first change comes P+1 cycles after the control write that starts it.
- R4: A down count ends at zero and an up count ends at all ones. The tick that brings the count to that value sets the status bit.
- R5: With auto-restart, the tick that reaches the terminal value loads preload into count instead, and start stays set.
- R6: Without auto-restart, the count stays at the terminal value and start reads back as 0. No further ticks occur.
- R7: While halt is set, or while enable or start is clear, the count does not change.
- R8: Writing control with bit 6 set copies preload into count on that write. Bit 6 always reads as 0.
- R9: Writing control with bit 4 set returns every register to zero, whatever else is written. Bit 4 always reads as 0.
- R10: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged.
- R11: The irq output is high exactly while both the status flag and interrupt enable bit 0 are set.
- R12: A direct write to count takes effect even if a tick falls in the same cycle. That tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Byte offset of the register to read or write |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request level |

## Verification
The counting engine is exercised with a table of runs. Each run combines a direction, a restart mode, a prescale value and a preload chosen to stop just short of, land on, or cross the terminal value. Comparing the final count, status and start fields tells the prescale rate apart from the step direction. It also separates a one-shot stop from an auto-restart reload. Directed sequences then halt and resume a running count, overwrite the count mid-run, and issue the reload and soft-reset commands. They also probe the write-one-to-clear status and interrupt gating, and check 16-bit masking of wide writes.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
   // register byte offsets
   localparam logic [4:0] OFS_COUNT   = 5'h00;
   localparam logic [4:0] OFS_PRELOAD = 5'h04;
   localparam logic [4:0] OFS_STATUS  = 5'h08;
   localparam logic [4:0] OFS_IEN     = 5'h0C;
   localparam logic [4:0] OFS_CTRL    = 5'h10;

   // control bit positions
   localparam int BIT_EN     = 0;
   localparam int BIT_UP     = 2;
   localparam int BIT_AUTO   = 3;
   localparam int BIT_SRST   = 4;
   localparam int BIT_START  = 5;
   localparam int BIT_RELOAD = 6;
   localparam int BIT_HALT   = 7;
   localparam int PS_LSB     = 16;
   localparam int PS_FIELD_W = 16;

   typedef struct packed {
      logic [PS_FIELD_W-1:0] prescale;
      logic                  halt;
      logic                  start;
      logic                  autorst;
      logic                  up;
      logic                  en;
   } ctrl_t;
endpackage

// File: rtl/ptmr_presc.sv
module ptmr_presc #(
   parameter int PS_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PS_W-1:0] limit,
   output logic            tick
);
   logic [PS_W-1:0] div_q;

   assign tick = run && (div_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       div_q <= '0;
      else if (!run)    div_q <= '0;
      else if (tick)    div_q <= '0;
      else              div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] wval,
   input  logic             reload,
   input  logic [CNT_W-1:0] preload,
   input  logic             tick,
   input  logic             up,
   input  logic             autorst,
   output logic [CNT_W-1:0] cnt_q,
   output logic             hit_evt
);
   logic [CNT_W-1:0] step_val;
   logic [CNT_W-1:0] term_val;
   logic             step_ok;

   assign step_val = up ? cnt_q + 1'b1 : cnt_q - 1'b1;
   assign term_val = up ? {CNT_W{1'b1}} : {CNT_W{1'b0}};
   assign step_ok  = tick && !cnt_wr && !reload && !srst;
   assign hit_evt  = step_ok && (step_val == term_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (srst)     cnt_q <= '0;
      else if (cnt_wr)   cnt_q <= wval;
      else if (reload)   cnt_q <= preload;
      else if (hit_evt)  cnt_q <= autorst ? preload : term_val;
      else if (step_ok)  cnt_q <= step_val;
   end
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
   import ptmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic              hit_evt,
   output ctrl_t             ctrl_q,
   output logic [CNT_W-1:0]  preload_q,
   output logic              status_q,
   output logic              ien_q,
   output logic              cnt_wr,
   output logic              reload_req,
   output logic              srst_req,
   output logic [31:0]       rd_data
);
   localparam int PAD_W = 32 - CNT_W;

   logic sel_cnt, sel_pre, sel_sts, sel_ien, sel_ctl;
   logic [31:0] cnt_ext, pre_ext, ctl_rd;
   logic unused_wbits;

   assign sel_cnt = (addr == ADDR_W'(OFS_COUNT));
   assign sel_pre = (addr == ADDR_W'(OFS_PRELOAD));
   assign sel_sts = (addr == ADDR_W'(OFS_STATUS));
   assign sel_ien = (addr == ADDR_W'(OFS_IEN));
   assign sel_ctl = (addr == ADDR_W'(OFS_CTRL));

   assign srst_req   = wr_en && sel_ctl && wdata[BIT_SRST];
   assign reload_req = wr_en && sel_ctl && wdata[BIT_RELOAD] && !wdata[BIT_SRST];
   assign cnt_wr     = wr_en && sel_cnt;

   assign unused_wbits = ^{wdata[15:8], wdata[1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         preload_q <= '0;
         status_q  <= 1'b0;
         ien_q     <= 1'b0;
      end else if (srst_req) begin
         ctrl_q    <= '0;
         preload_q <= '0;
         status_q  <= 1'b0;
         ien_q     <= 1'b0;
      end else begin
         if (wr_en && sel_ctl) begin
            ctrl_q.prescale <= wdata[PS_LSB +: PS_FIELD_W];
            ctrl_q.halt     <= wdata[BIT_HALT];
            ctrl_q.start    <= wdata[BIT_START];
            ctrl_q.autorst  <= wdata[BIT_AUTO];
            ctrl_q.up       <= wdata[BIT_UP];
            ctrl_q.en       <= wdata[BIT_EN];
         end else if (hit_evt && !ctrl_q.autorst) begin
            ctrl_q.start    <= 1'b0;
         end
         if (wr_en && sel_pre) preload_q <= wdata[CNT_W-1:0];
         if (wr_en && sel_ien) ien_q     <= wdata[0];
         if (hit_evt)                           status_q <= 1'b1;
         else if (wr_en && sel_sts && wdata[0]) status_q <= 1'b0;
      end
   end

   // zero extension depends on the counter width variant
   if (PAD_W > 0) begin : g_pad
      assign cnt_ext = {{PAD_W{1'b0}}, cnt_q};
      assign pre_ext = {{PAD_W{1'b0}}, preload_q};
   end else begin : g_full
      assign cnt_ext = cnt_q;
      assign pre_ext = preload_q;
   end

   assign ctl_rd = {ctrl_q.prescale, 8'h00, ctrl_q.halt, 1'b0, ctrl_q.start,
                    1'b0, ctrl_q.autorst, ctrl_q.up, 1'b0, ctrl_q.en};

   always_comb begin
      rd_data = '0;
      if (sel_cnt) rd_data = cnt_ext;
      if (sel_pre) rd_data = pre_ext;
      if (sel_sts) rd_data = {31'd0, status_q};
      if (sel_ien) rd_data = {31'd0, ien_q};
      if (sel_ctl) rd_data = ctl_rd;
   end
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
   import ptmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 5,
   parameter int PS_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rd_data,
   output logic              irq
);
   // elaboration-time parameter checks
   if (!(CNT_W == 16 || CNT_W == 32)) begin : g_bad_cnt_w
      $error("prescaled_timer: CNT_W must be 16 or 32");
   end
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("prescaled_timer: ADDR_W must reach offset 0x10");
   end
   if (PS_W != PS_FIELD_W) begin : g_bad_ps_w
      $error("prescaled_timer: PS_W must match the control prescale field");
   end

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] preload_q;
   logic [CNT_W-1:0] cnt_q;
   logic             status_q, ien_q;
   logic             cnt_wr, reload_req, srst_req;
   logic             hit_evt, tick, run;

   assign run = ctrl_q.en && ctrl_q.start && !ctrl_q.halt;
   assign irq = status_q && ien_q;

   ptmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .cnt_q(cnt_q), .hit_evt(hit_evt), .ctrl_q(ctrl_q), .preload_q(preload_q),
      .status_q(status_q), .ien_q(ien_q), .cnt_wr(cnt_wr),
      .reload_req(reload_req), .srst_req(srst_req), .rd_data(rd_data)
   );

   ptmr_presc #(.PS_W(PS_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(run),
      .limit(ctrl_q.prescale[PS_W-1:0]), .tick(tick)
   );

   ptmr_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .srst(srst_req), .cnt_wr(cnt_wr),
      .wval(wdata[CNT_W-1:0]), .reload(reload_req), .preload(preload_q),
      .tick(tick), .up(ctrl_q.up), .autorst(ctrl_q.autorst),
      .cnt_q(cnt_q), .hit_evt(hit_evt)
   );
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk
   import ptmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [CNT_W-1:0] cnt_q,
   input logic             status_q,
   input logic             ien_q,
   input logic             run,
   input logic             tick,
   input logic             hit_evt,
   input logic             irq,
   input ctrl_t            ctrl_q
);
   // R3: the prescaler only ticks while the timer is running
   a_r3_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> run);

   // R3: an ordinary tick moves the count by exactly one
   a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_en && !hit_evt) |=>
         ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1)));

   // R7: a stopped timer holds its count
   a_r7_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_en) |=> $stable(cnt_q));

   // R5: auto-restart keeps running after the terminal tick
   a_r5_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_evt && ctrl_q.autorst && !wr_en) |=> (ctrl_q.start && status_q));

   // R6: one-shot mode stops after the terminal tick
   a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_evt && !ctrl_q.autorst && !wr_en) |=> (!ctrl_q.start && status_q));

   // R10: the status flag stays set until software writes
   a_r10_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !wr_en) |=> status_q);

   // R11: an enabled pending flag keeps the interrupt asserted
   a_r11_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && ien_q && !wr_en) |=> irq);
endmodule

bind prescaled_timer ptmr_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cnt_q(cnt_q),
   .status_q(status_q), .ien_q(ien_q), .run(run), .tick(tick),
   .hit_evt(hit_evt), .irq(irq), .ctrl_q(ctrl_q)
);

// File: tb/prescaled_timer_test.sv
module prescaled_timer_test;
   localparam int ADDR_W = 5;
   localparam int NV     = 6;

   // stimulus: prescale, up, auto, preload, cycles to wait
   localparam int unsigned V_PS  [NV] = '{0, 0, 2, 1, 0, 3};
   localparam int unsigned V_UP  [NV] = '{0, 0, 0, 1, 1, 1};
   localparam int unsigned V_AU  [NV] = '{0, 0, 1, 0, 1, 0};
   localparam int unsigned V_PRE [NV] = '{5, 3, 4, 32'hFFFC, 32'hFFFE, 32'h10};
   localparam int unsigned V_CYC [NV] = '{3, 5, 12, 10, 3, 7};
   // expected: count, status, start
   localparam int unsigned E_CNT [NV] = '{2, 0, 4, 32'hFFFF, 32'hFFFE, 32'h11};
   localparam int unsigned E_STS [NV] = '{0, 1, 1, 1, 1, 0};
   localparam int unsigned E_STA [NV] = '{1, 0, 1, 0, 1, 1};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [31:0]       wdata = '0;
   logic [31:0]       rd_data;
   logic              irq;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   prescaled_timer #(.CNT_W(16), .ADDR_W(ADDR_W), .PS_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rd_data(rd_data), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the write edge
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      addr = ADDR_W'(a);
      #1;
      d = rd_data;
   endtask

   function automatic logic [31:0] ctl(input int unsigned ps, input bit up,
      input bit au, input bit st, input bit hl, input bit rl);
      return (ps << 16) | (32'(hl) << 7) | (32'(rl) << 6) | (32'(st) << 5)
           | (32'(au) << 3) | (32'(up) << 2) | 32'd1;
   endfunction

   initial begin : watchdog
      #(20 * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values and offsets
      rd(5'h00, v); check("R1 count reset", v, 0);
      rd(5'h04, v); check("R1 preload reset", v, 0);
      rd(5'h08, v); check("R1 status reset", v, 0);
      rd(5'h0C, v); check("R1 ien reset", v, 0);
      rd(5'h10, v); check("R1 ctrl reset", v, 0);
      check("R11 irq reset", 32'(irq), 0);
      wr(5'h04, 32'h0000ABCD); rd(5'h04, v); check("R1 preload offset", v, 32'hABCD);
      wr(5'h0C, 32'h1);        rd(5'h0C, v); check("R1 ien offset", v, 1);
      wr(5'h10, 32'h000300AD); rd(5'h10, v); check("R3 ctrl layout", v, 32'h000300AD);
      // R8: reload copies preload and reads back as zero
      wr(5'h10, 32'h000300ED);
      rd(5'h00, v); check("R8 reload count", v, 32'hABCD);
      rd(5'h10, v); check("R8 reload bit reads 0", v, 32'h000300AD);

      // R2: 16-bit masking
      wr(5'h00, 32'h12345678); rd(5'h00, v); check("R2 count mask", v, 32'h5678);
      wr(5'h04, 32'hFFFF1111); rd(5'h04, v); check("R2 preload mask", v, 32'h1111);

      // table of counting runs: R3 R4 R5 R6
      for (int i = 0; i < NV; i++) begin
         wr(5'h10, 32'h10);
         wr(5'h04, V_PRE[i]);
         wr(5'h10, ctl(V_PS[i], V_UP[i][0], V_AU[i][0], 1'b1, 1'b0, 1'b1));
         repeat (V_CYC[i]) @(negedge clk);
         rd(5'h00, v); check($sformatf("R3/R4 vec%0d count", i), v, E_CNT[i]);
         rd(5'h08, v); check($sformatf("R4 vec%0d status", i), v, E_STS[i]);
         rd(5'h10, v); check($sformatf("R5/R6 vec%0d start", i), 32'(v[5]), E_STA[i]);
      end

      // R7: halt freezes, resume continues
      wr(5'h10, 32'h10);
      wr(5'h04, 100);
      wr(5'h10, ctl(0, 0, 0, 1, 0, 1));
      repeat (2) @(negedge clk);
      wr(5'h10, ctl(0, 0, 0, 1, 1, 0));
      repeat (5) @(negedge clk);
      rd(5'h00, v); check("R7 halt holds", v, 97);
      wr(5'h10, ctl(0, 0, 0, 1, 0, 0));
      repeat (2) @(negedge clk);
      rd(5'h00, v); check("R7 resume", v, 95);

      // R12: count write wins over a tick
      wr(5'h00, 50);
      rd(5'h00, v); check("R12 write wins", v, 50);
      @(negedge clk);
      rd(5'h00, v); check("R12 next tick", v, 49);

      // R10 / R11: status and interrupt
      wr(5'h10, 32'h10);
      wr(5'h04, 2);
      wr(5'h10, ctl(0, 0, 0, 1, 0, 1));
      repeat (3) @(negedge clk);
      rd(5'h08, v); check("R4 down hit", v, 1);
      check("R11 irq masked", 32'(irq), 0);
      wr(5'h0C, 1);
      check("R11 irq enabled", 32'(irq), 1);
      wr(5'h08, 0);
      rd(5'h08, v); check("R10 write 0 keeps", v, 1);
      wr(5'h08, 1);
      rd(5'h08, v); check("R10 write 1 clears", v, 0);
      check("R11 irq cleared", 32'(irq), 0);

      // R9: soft reset clears everything
      wr(5'h04, 32'h55);
      wr(5'h00, 32'h33);
      wr(5'h10, ctl(5, 1, 1, 0, 0, 0));
      wr(5'h10, 32'hFFFF_FFFF);
      rd(5'h00, v); check("R9 count", v, 0);
      rd(5'h04, v); check("R9 preload", v, 0);
      rd(5'h08, v); check("R9 status", v, 0);
      rd(5'h0C, v); check("R9 ien", v, 0);
      rd(5'h10, v); check("R9 ctrl and self-clear", v, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule